// File: doc/BRIEF.md
# Windowed Watchdog Timer with Key Sequence

This block is a free-running watchdog timer. A 3-bit rate select either holds the watchdog off or sets one of seven power-of-two timeout periods. The counter advances on every clock cycle that the low-power gating lets through. Software shows that it is still alive by writing a two-byte key into an arm register. The first byte must be 0x55 and the second 0xAA, and a complete key starts a fresh period.

When the window bit is set, an arm write counts as legitimate only in the last quarter of the period. Three events raise a one-cycle reset request, which goes to the chip's reset generator:

- the period runs out,
- an illegal byte is written,
- a write arrives too early while the window is on.

A 2-bit cause output tells the three events apart. The counting clock is qualified by wait and stop mode inputs. Wait mode can freeze the count. Stop mode freezes it unless pseudo-stop is active with the continue bit set.

Top module: `wdog_keyed`

## Requirements
- R1: After reset `rst_req` is 0 and `rst_cause` is 2'b00. While `rate_sel` is 3'b000 the watchdog does not count and issues no request, even when arm writes of any value occur.
- R2: With `BASE_LOG2` = B, the timeout period in counting cycles is 2^(B+k). The value of k depends on `rate_sel`: 0 for 001, 2 for 010, 4 for 011, 6 for 100, 8 for 101, 9 for 110 and 10 for 111. When the count expires, a request is issued with cause 2'b01.
- R3: A write of 0x55 followed by a write of 0xAA restarts the period from zero without a request. A repeated 0x55 before the 0xAA only re-arms the first step.
- R4: An arm write of any byte other than 0x55 or 0xAA issues a request with cause 2'b10.
- R5: A write of 0xAA whose preceding arm write was not 0x55 issues a request with cause 2'b10.
- R6: With `win_en` = 1, an arm write issued while the count is below three quarters of the period issues a request with cause 2'b11. This cause takes priority over the key checks. A write at a count equal to the boundary is accepted, for example count 48 of a 64-cycle period.
- R7: Counting stops while `in_wait` and `wait_frz` are both 1. Counting also stops while `in_stop` is 1, unless `in_pstop` and `pstop_cont` are both 1.
- R8: A request is a single-cycle pulse on `rst_req` in the cycle after the event. It clears the counter and the key state, so a full new period follows. `rst_cause` is nonzero with the pulse and holds until the next request. A completed key in the expiring cycle suppresses the timeout.
- R9: A change of `rate_sel` clears the counter and the key state, and the new period starts at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate_sel | input | 3 | Timeout select, 0 = disabled |
| win_en | input | 1 | Window mode enable |
| wait_frz | input | 1 | Freeze the count in wait mode |
| pstop_cont | input | 1 | Keep counting in pseudo-stop |
| in_wait | input | 1 | Core is in wait mode |
| in_stop | input | 1 | Core is in stop mode |
| in_pstop | input | 1 | Stop mode is pseudo-stop |
| arm_we | input | 1 | Arm register write strobe |
| arm_data | input | 8 | Arm register write data |
| rst_req | output | 1 | One-cycle reset request |
| rst_cause | output | 2 | Cause of the last request: 01 timeout, 10 bad key, 11 early write |

## Verification
The bench builds the block with `BASE_LOG2` = 4. This shrinks the shortest period to 16 cycles and the longest to 16384 cycles. The exact expiry cycle can then be measured for selects 001, 010, 011 and 111 within a short run. The small periods also put the three-quarter window boundary at counts 12 and 48, where the bench probes one cycle on each side of it.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'b00,
        CAUSE_TIMEOUT = 2'b01,
        CAUSE_KEY     = 2'b10,
        CAUSE_EARLY   = 2'b11
    } wd_cause_e;

    typedef enum logic {
        KEY_IDLE,
        KEY_HALF
    } key_state_e;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    // extra doublings of the base period for each select value
    function automatic int unsigned sel_extra(input logic [2:0] sel);
        case (sel)
            3'd2:    sel_extra = 2;
            3'd3:    sel_extra = 4;
            3'd4:    sel_extra = 6;
            3'd5:    sel_extra = 8;
            3'd6:    sel_extra = 9;
            3'd7:    sel_extra = 10;
            default: sel_extra = 0;
        endcase
    endfunction

endpackage

// File: rtl/wdog_gate.sv
module wdog_gate (
    input  logic wait_frz,
    input  logic pstop_cont,
    input  logic in_wait,
    input  logic in_stop,
    input  logic in_pstop,
    output logic tick_en
);
    logic wait_hold;
    logic stop_hold;

    assign wait_hold = in_wait && wait_frz;
    assign stop_hold = in_stop && !(in_pstop && pstop_cont);
    assign tick_en   = !wait_hold && !stop_hold;
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int unsigned BASE_LOG2 = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       clr,
    input  logic [2:0] sel,
    output logic       at_end,
    output logic       win_open
);
    import wdog_pkg::*;

    localparam int unsigned CW = BASE_LOG2 + 10;

    logic [CW-1:0] cnt_q;
    logic [CW:0]   period;
    logic [CW-1:0] last;
    logic [CW-1:0] boundary;

    always_comb begin
        period   = (CW+1)'(1) << (BASE_LOG2 + sel_extra(sel));
        last     = period[CW-1:0] - 1'b1;
        boundary = period[CW:1] + {1'b0, period[CW:2]};
    end

    assign at_end   = tick && (cnt_q == last);
    assign win_open = cnt_q >= boundary;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (tick)   cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/wdog_keyfsm.sv
module wdog_keyfsm (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       wr,
    input  logic [7:0] data,
    input  logic       win_ok,
    output logic       restart,
    output logic       key_err,
    output logic       win_err
);
    import wdog_pkg::*;

    key_state_e state_q;
    key_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KEY_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        restart = 1'b0;
        key_err = 1'b0;
        win_err = 1'b0;
        unique case (state_q)
            KEY_IDLE: begin
                if (wr) begin
                    if (!win_ok)                 win_err = 1'b1;
                    else if (data == KEY_FIRST)  state_d = KEY_HALF;
                    else                         key_err = 1'b1;
                end
            end
            KEY_HALF: begin
                if (wr) begin
                    if (!win_ok) begin
                        win_err = 1'b1;
                        state_d = KEY_IDLE;
                    end else if (data == KEY_FIRST) begin
                        state_d = KEY_HALF;
                    end else if (data == KEY_SECOND) begin
                        restart = 1'b1;
                        state_d = KEY_IDLE;
                    end else begin
                        key_err = 1'b1;
                        state_d = KEY_IDLE;
                    end
                end
            end
        endcase
        if (clr) state_d = KEY_IDLE;
    end
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed #(
    parameter int unsigned BASE_LOG2 = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] rate_sel,
    input  logic       win_en,
    input  logic       wait_frz,
    input  logic       pstop_cont,
    input  logic       in_wait,
    input  logic       in_stop,
    input  logic       in_pstop,
    input  logic       arm_we,
    input  logic [7:0] arm_data,
    output logic       rst_req,
    output logic [1:0] rst_cause
);
    import wdog_pkg::*;

    logic [2:0] sel_q;
    logic       run_en;
    logic       sel_chg;
    logic       tick_en;
    logic       tick;
    logic       at_end;
    logic       win_open;
    logic       restart;
    logic       key_err;
    logic       win_err;
    logic       expire;
    logic       req_now;
    logic       cnt_clr;
    logic       fsm_clr;
    wd_cause_e  cause_d;
    wd_cause_e  cause_q;
    logic       req_q;

    assign run_en  = rate_sel != 3'd0;
    assign sel_chg = rate_sel != sel_q;
    assign tick    = run_en && tick_en;
    assign expire  = at_end && !restart && !sel_chg;
    assign req_now = run_en && (win_err || key_err || expire);
    assign cnt_clr = !run_en || sel_chg || req_now || restart;
    assign fsm_clr = !run_en || sel_chg || expire;

    wdog_gate u_gate (
        .wait_frz   (wait_frz),
        .pstop_cont (pstop_cont),
        .in_wait    (in_wait),
        .in_stop    (in_stop),
        .in_pstop   (in_pstop),
        .tick_en    (tick_en)
    );

    wdog_counter #(.BASE_LOG2(BASE_LOG2)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .clr      (cnt_clr),
        .sel      (rate_sel),
        .at_end   (at_end),
        .win_open (win_open)
    );

    wdog_keyfsm u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (fsm_clr),
        .wr      (arm_we && run_en),
        .data    (arm_data),
        .win_ok  (!win_en || win_open),
        .restart (restart),
        .key_err (key_err),
        .win_err (win_err)
    );

    always_comb begin
        cause_d = cause_q;
        if (req_now) begin
            if (win_err)      cause_d = CAUSE_EARLY;
            else if (key_err) cause_d = CAUSE_KEY;
            else              cause_d = CAUSE_TIMEOUT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= 3'd0;
            req_q   <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else begin
            sel_q   <= rate_sel;
            req_q   <= req_now;
            cause_q <= cause_d;
        end
    end

    assign rst_req   = req_q;
    assign rst_cause = cause_q;
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] rate_sel,
    input logic       win_en,
    input logic       wait_frz,
    input logic       in_wait,
    input logic       arm_we,
    input logic [7:0] arm_data,
    input logic       win_open,
    input logic       rst_req,
    input logic [1:0] rst_cause
);
    import wdog_pkg::*;

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == 3'd0) |=> !rst_req); // R1

    AST_BAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_we && rate_sel != 3'd0 && arm_data != KEY_FIRST && arm_data != KEY_SECOND)
        |=> (rst_req && (rst_cause == CAUSE_KEY || rst_cause == CAUSE_EARLY))); // R4

    AST_EARLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_we && rate_sel != 3'd0 && win_en && !win_open)
        |=> (rst_req && rst_cause == CAUSE_EARLY)); // R6

    AST_WAIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && wait_frz && !arm_we) |=> !rst_req); // R7

    AST_CAUSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (rst_cause != CAUSE_NONE)); // R8

    AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_req |-> $stable(rst_cause)); // R8
endmodule

bind wdog_keyed wdog_keyed_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate_sel  (rate_sel),
    .win_en    (win_en),
    .wait_frz  (wait_frz),
    .in_wait   (in_wait),
    .arm_we    (arm_we),
    .arm_data  (arm_data),
    .win_open  (win_open),
    .rst_req   (rst_req),
    .rst_cause (rst_cause)
);

// File: tb/wdog_keyed_tb.sv
`timescale 1ns/1ps
module wdog_keyed_tb;
    localparam int unsigned BASE = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] rate_sel = '0;
    logic       win_en = 1'b0, wait_frz = 1'b0, pstop_cont = 1'b0;
    logic       in_wait = 1'b0, in_stop = 1'b0, in_pstop = 1'b0;
    logic       arm_we = 1'b0;
    logic [7:0] arm_data = '0;
    logic       rst_req;
    logic [1:0] rst_cause;

    int n_chk = 0;
    int n_fail = 0;
    logic seen_req;

    always #5 clk = ~clk;

    wdog_keyed #(.BASE_LOG2(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .win_en(win_en),
        .wait_frz(wait_frz), .pstop_cont(pstop_cont), .in_wait(in_wait),
        .in_stop(in_stop), .in_pstop(in_pstop), .arm_we(arm_we),
        .arm_data(arm_data), .rst_req(rst_req), .rst_cause(rst_cause)
    );

    function automatic int exp_period(input int sel);
        int k;
        case (sel)
            1: k = 0;  2: k = 2;  3: k = 4;  4: k = 6;
            5: k = 8;  6: k = 9;  default: k = 10;
        endcase
        return 1 << (BASE + k);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rate_sel = '0; win_en = 0; wait_frz = 0; pstop_cont = 0;
        in_wait = 0; in_stop = 0; in_pstop = 0; arm_we = 0; arm_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic start(input int sel, input logic win);
        rate_sel = 3'(sel); win_en = win;
        @(negedge clk);
    endtask

    task automatic idle(input int m);
        seen_req = 1'b0;
        for (int i = 0; i < m; i++) begin
            @(negedge clk);
            if (rst_req) seen_req = 1'b1;
        end
    endtask

    task automatic wr(input logic [7:0] d);
        arm_we = 1'b1; arm_data = d;
        @(negedge clk);
        arm_we = 1'b0;
    endtask

    task automatic count_to_req(input int limit, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!rst_req && n < limit);
    endtask

    task automatic t_reset_disabled();
        do_reset();
        chk("R1 reset rst_req", rst_req, 0);
        chk("R1 reset rst_cause", rst_cause, 0);
        idle(100);
        wr(8'h12);
        idle(40);
        chk("R1 disabled no request", seen_req || rst_req, 0);
    endtask

    task automatic t_timeout(input int sel);
        int n;
        do_reset();
        start(sel, 0);
        count_to_req(20000, n);
        chk("R2 timeout period", n, exp_period(sel));
        chk("R2 timeout cause", rst_cause, 1);
        @(negedge clk);
        chk("R8 pulse one cycle", rst_req, 0);
        count_to_req(20000, n);
        chk("R8 full period after request", n + 1, exp_period(sel));
    endtask

    task automatic t_key_ok();
        int n;
        do_reset();
        start(1, 0);
        idle(5);
        wr(8'h55); wr(8'h55); wr(8'hAA);
        chk("R3 key accepted", seen_req || rst_req, 0);
        count_to_req(200, n);
        chk("R3 period restarted", n, 16);
    endtask

    task automatic t_bad_value();
        int n;
        do_reset();
        start(1, 0);
        idle(2);
        wr(8'h33);
        chk("R4 bad byte request", rst_req, 1);
        chk("R4 bad byte cause", rst_cause, 2);
        count_to_req(200, n);
        chk("R8 counter cleared after fault", n, 16);
        do_reset();
        start(1, 0);
        wr(8'h55); wr(8'h00);
        chk("R4 bad second byte", {rst_req, rst_cause}, 3'b110);
    endtask

    task automatic t_lone_aa();
        do_reset();
        start(1, 0);
        idle(3);
        wr(8'hAA);
        chk("R5 AA without 55", {rst_req, rst_cause}, 3'b110);
    endtask

    task automatic t_window();
        int n;
        do_reset();
        start(1, 1);
        idle(11);
        wr(8'h55);
        chk("R6 early write count 11", {rst_req, rst_cause}, 3'b111);
        do_reset();
        start(1, 1);
        idle(3);
        wr(8'h33);
        chk("R6 early priority over bad byte", rst_cause, 3);
        do_reset();
        start(1, 1);
        idle(12);
        wr(8'h55); wr(8'hAA);
        chk("R6 write at boundary 12 accepted", seen_req || rst_req, 0);
        count_to_req(200, n);
        chk("R6 restart in window", n, 16);
        do_reset();
        start(2, 1);
        idle(47);
        wr(8'h55);
        chk("R6 early write count 47", {rst_req, rst_cause}, 3'b111);
        do_reset();
        start(2, 1);
        idle(48);
        wr(8'h55);
        chk("R6 write at count 48 accepted", rst_req, 0);
    endtask

    task automatic t_gating();
        int n;
        do_reset();
        wait_frz = 1; in_wait = 1;
        start(1, 0);
        idle(50);
        chk("R7 wait freeze", seen_req, 0);
        in_wait = 0;
        count_to_req(200, n);
        chk("R7 resume after wait", n, 16);
        do_reset();
        wait_frz = 0; in_wait = 1;
        start(1, 0);
        count_to_req(200, n);
        chk("R7 wait without freeze runs", n, 16);
        do_reset();
        in_stop = 1; pstop_cont = 1; in_pstop = 0;
        start(1, 0);
        idle(40);
        chk("R7 full stop frozen", seen_req, 0);
        in_pstop = 1;
        count_to_req(200, n);
        chk("R7 pseudo-stop continues", n, 16);
    endtask

    task automatic t_sel_change();
        int n;
        do_reset();
        start(1, 0);
        idle(10);
        start(2, 0);
        count_to_req(500, n);
        chk("R9 new period after select change", n, 64);
        do_reset();
        start(1, 0);
        wr(8'h55);
        start(3, 0);
        wr(8'hAA);
        chk("R9 key state cleared", {rst_req, rst_cause}, 3'b110);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset_disabled();
        t_timeout(1);
        t_timeout(2);
        t_timeout(3);
        t_timeout(7);
        t_key_ok();
        t_bad_value();
        t_lone_aa();
        t_window();
        t_gating();
        t_sel_change();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule